// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a word-organised serial EEPROM. An external master controls it with a chip select, a serial clock, a serial data input and a serial data output. Tri-state is modelled by a separate output enable. Every instruction starts with a framing 1. Next come a two-bit operation code and a word address. A write instruction then carries a 16-bit data word. The store holds `WORDS` words of 16 bits; the default is 1024 words, with a 10-bit address.

The model reads with an open-ended sequential stream, writes single words and has two instructions that set and clear a write-enable latch. A write does not update the array at once. The programming step begins when chip select falls after the last data bit. A cycle counter of `PROG_CYCLES` system clocks stands in for the self-timed delay. While chip select is high, the data output shows busy (0) or ready (1).

The serial pins are asynchronous to the system clock. They are brought into that domain through a synchronizer, and only rising serial-clock edges are acted on. At reset every word holds the erased value 16'hFFFF.

Top module: `mw_eeprom_slave`

## Requirements
- R1: Zeros clocked in while chip select is high and the decoder is idle are ignored. The first 1 sampled on a rising serial-clock edge is the framing bit, so both "1" and "01" start an instruction.
- R2: After the framing bit come two operation bits, then the address, each sent MSB first. Operation 10 is read and 01 is write. Operation 00 is a control group, decoded from the two most significant address bits: 11 sets the write-enable latch, 00 clears it, and 01 and 10 are accepted with no effect. Operation 11 is also accepted with no effect.
- R3: Reset clears the write-enable latch, and the clear instruction also clears it. While the latch is clear, a write instruction leaves the addressed word unchanged. Read does not depend on the latch.
- R4: With the latch set, a write stores its 16 data bits, MSB first, into the addressed word. The store happens `PROG_CYCLES` clocks after chip select falls following the last data bit.
- R5: From that chip-select fall until the next framing bit, the output enable is high whenever chip select is high. The data output is 0 while programming runs and 1 once it is done. While chip select is low, the output enable is 0.
- R6: While programming runs, framing bits and whole instructions are ignored. This includes a latch-clear instruction.
- R7: A read drives a 0 on the data output after the last address bit. It then drives the addressed word MSB first, one bit per rising serial-clock edge, with the output enable high.
- R8: While the serial clock keeps running in a read, the next word follows directly after each 16 bits. The address increments and wraps from WORDS-1 to 0.
- R9: Chip select going low before an instruction completes aborts it with no side effect. The next framing bit starts a fresh instruction.
- R10: After reset the output enable is 0, even with chip select high, and every word reads 16'hFFFF.
- R11: The write-all control code (00 then 01) changes no word and starts no programming step, so no busy/ready status follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high, asynchronous |
| sk | input | 1 | Serial clock from the master, asynchronous |
| di | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out (read data or busy/ready) |
| sdo_en | output | 1 | Output enable standing in for the tri-state driver |

## Verification
The bench goes after four kinds of corner case:
- **Read wrap.** A read started at the top address must continue into word 0 and then word 1. A design that stopped, re-inserted the dummy bit or failed to wrap would return wrong data on the second and third words.
- **Start bit and aborts.** Leading zeros before the framing bit, and a chip-select drop halfway through an address or a data word, are both driven. A decoder that counted the zeros, or committed a partial word, would read back garbage.
- **Status output.** Status is checked busy, then ready, then across a chip-select low period. The check confirms the status output keeps going until a framing bit arrives and stops after it.
- **Write gating.** Writes are tried with the latch cleared by reset, by the clear instruction and with a clear instruction sent during busy. A design that ignored the latch, or that decoded instructions while busy, would change a word that must stay erased, or refuse a write that must land.

// File: rtl/mw_eeprom_pkg.sv
// Shared encodings for the serial EEPROM slave model.
// Assumes: operation codes are two bits, sent MSB first after the framing bit.
package mw_eeprom_pkg;

    // Decoder phases of one serial instruction.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for the framing 1
        ST_OPC,    // collecting the two operation bits
        ST_ADDR,   // collecting the address
        ST_WDATA,  // collecting write data
        ST_RDATA,  // streaming read data
        ST_WAITCS  // instruction complete, waiting for chip select to drop
    } dec_state_t;

    // Operation field values.
    typedef enum logic [1:0] {
        OPC_CTRL  = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_RSVD  = 2'b11
    } opcode_t;

    // Control group sub-codes, taken from the two top address bits.
    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_SPARE  = 2'b10,
        SUB_UNLOCK = 2'b11
    } subop_t;

endpackage

// File: rtl/mw_in_sync.sv
// Brings the asynchronous serial pins into the system clock domain.
// Assumes: all three pins travel through synchronizers of equal depth, so
// data and clock stay aligned; the serial clock is much slower than clk.
module mw_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise,
    output logic cs_fall
);
    logic [STAGES-1:0] sk_p, cs_p, di_p;
    logic              sk_d, cs_d;
    logic              sk_s;

    // Shift each pin through its synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_p <= '0;
            cs_p <= '0;
            di_p <= '0;
        end else begin
            sk_p <= {sk_p[STAGES-2:0], sk};
            cs_p <= {cs_p[STAGES-2:0], cs};
            di_p <= {di_p[STAGES-2:0], di};
        end
    end

    // Keep one delayed copy of clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_d <= 1'b0;
            cs_d <= 1'b0;
        end else begin
            sk_d <= sk_s;
            cs_d <= cs_s;
        end
    end

    assign sk_s    = sk_p[STAGES-1];
    assign cs_s    = cs_p[STAGES-1];
    assign di_s    = di_p[STAGES-1];
    assign sk_rise = sk_s & ~sk_d;
    assign cs_fall = cs_d & ~cs_s;

endmodule

// File: rtl/mw_prog_timer.sv
// Stands in for the self-timed programming delay.
// Assumes: start never arrives while busy; commit pulses in the last busy cycle.
module mw_prog_timer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic commit
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load the delay on start and count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)   cnt <= cnt - CW'(1);
    end

    assign busy   = (cnt != '0);
    assign commit = (cnt == CW'(1));

endmodule

// File: rtl/mw_word_store.sv
// Word array with one combinational read port and one clocked write port.
// Assumes: reset puts every word in the erased all-ones state.
module mw_word_store #(
    parameter int WORDS  = 1024,
    parameter int WORD_W = 16,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [WORDS];

    // Erase on reset, otherwise take the committed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mw_cmd_decoder.sv
// Serial instruction decoder: framing, operation, address, data, read stream,
// write-enable latch and busy/ready status mode.
// Assumes: inputs are already synchronous; one action per rising serial edge.
module mw_cmd_decoder
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              di_s,
    input  logic              sk_rise,
    input  logic              cs_fall,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              prog_start,
    output logic              wel,
    output logic              status_mode,
    output logic              rd_active,
    output logic              dec_idle,
    output logic              sdo_bit
);
    localparam int MAXF  = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
    localparam int CNT_W = $clog2(MAXF + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

    dec_state_t        state;
    opcode_t           opc;
    logic [CNT_W-1:0]  bitcnt;
    logic [ADDR_W-1:0] sh_addr;
    logic [WORD_W-1:0] sh_data;
    logic [WORD_W-1:0] rd_shift;
    logic              wr_pend;
    logic [ADDR_W-1:0] addr_next;
    logic [WORD_W-1:0] data_next;
    subop_t            sub;

    // Next values of the shift registers with the current serial bit.
    always_comb begin
        addr_next = {sh_addr[ADDR_W-2:0], di_s};
        data_next = {sh_data[WORD_W-2:0], di_s};
        sub       = subop_t'(addr_next[ADDR_W-1 -: 2]);
    end

    // Instruction sequencing on synchronized serial-clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            opc         <= OPC_CTRL;
            bitcnt      <= '0;
            sh_addr     <= '0;
            sh_data     <= '0;
            rd_shift    <= '0;
            rd_addr     <= '0;
            wr_addr     <= '0;
            wr_data     <= '0;
            wr_pend     <= 1'b0;
            wel         <= 1'b0;
            status_mode <= 1'b0;
            prog_start  <= 1'b0;
            sdo_bit     <= 1'b0;
        end else begin
            prog_start <= 1'b0;
            if (!cs_s) begin
                state   <= ST_IDLE;
                wr_pend <= 1'b0;
                if (cs_fall && state == ST_WAITCS && wr_pend) begin
                    prog_start  <= 1'b1;
                    status_mode <= 1'b1;
                end
            end else if (sk_rise) begin
                unique case (state)
                    ST_IDLE: begin
                        if (di_s && !busy) begin
                            state       <= ST_OPC;
                            bitcnt      <= '0;
                            status_mode <= 1'b0;
                        end
                    end
                    ST_OPC: begin
                        opc <= opcode_t'({opc[0], di_s});
                        if (bitcnt == CNT_W'(1)) begin
                            state  <= ST_ADDR;
                            bitcnt <= '0;
                        end else begin
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                    ST_ADDR: begin
                        sh_addr <= addr_next;
                        bitcnt  <= bitcnt + CNT_W'(1);
                        if (bitcnt == ADDR_LAST) begin
                            bitcnt <= '0;
                            state  <= ST_WAITCS;
                            case (opc)
                                OPC_READ: begin
                                    state   <= ST_RDATA;
                                    rd_addr <= addr_next;
                                    sdo_bit <= 1'b0;
                                end
                                OPC_WRITE: state <= ST_WDATA;
                                OPC_CTRL: begin
                                    if (sub == SUB_UNLOCK)    wel <= 1'b1;
                                    else if (sub == SUB_LOCK) wel <= 1'b0;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_WDATA: begin
                        sh_data <= data_next;
                        bitcnt  <= bitcnt + CNT_W'(1);
                        if (bitcnt == WORD_LAST) begin
                            wr_addr <= sh_addr;
                            wr_data <= data_next;
                            wr_pend <= wel;
                            state   <= ST_WAITCS;
                        end
                    end
                    ST_RDATA: begin
                        if (bitcnt == '0) begin
                            sdo_bit  <= rd_word[WORD_W-1];
                            rd_shift <= {rd_word[WORD_W-2:0], 1'b0};
                        end else begin
                            sdo_bit  <= rd_shift[WORD_W-1];
                            rd_shift <= {rd_shift[WORD_W-2:0], 1'b0};
                        end
                        if (bitcnt == WORD_LAST) begin
                            bitcnt  <= '0;
                            rd_addr <= rd_addr + ADDR_W'(1);
                        end else begin
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_active = (state == ST_RDATA);
    assign dec_idle  = (state == ST_IDLE);

endmodule

// File: rtl/mw_eeprom_slave.sv
// Top of the serial EEPROM slave model: synchronizer, decoder, timer, array.
// Assumes: WORDS is a power of two, so the read address wraps naturally.
module mw_eeprom_slave #(
    parameter int WORDS       = 1024,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic sdo,
    output logic sdo_en
);
    localparam int ADDR_W = $clog2(WORDS);

    logic              cs_s, di_s, sk_rise, cs_fall;
    logic              busy, commit, prog_start, wel;
    logic              status_mode, rd_active, dec_idle, sdo_bit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [WORD_W-1:0] rd_word, wr_data;

    mw_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sk(sk), .cs(cs), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_cmd_decoder #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s),
        .sk_rise(sk_rise), .cs_fall(cs_fall), .busy(busy),
        .rd_word(rd_word), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_start(prog_start), .wel(wel),
        .status_mode(status_mode), .rd_active(rd_active),
        .dec_idle(dec_idle), .sdo_bit(sdo_bit)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start),
        .busy(busy), .commit(commit)
    );

    mw_word_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(commit), .waddr(wr_addr),
        .wdata(wr_data), .raddr(rd_addr), .rdata(rd_word)
    );

    // Output mux: status while reporting programming, else read data.
    always_comb begin
        sdo    = status_mode ? ~busy : sdo_bit;
        sdo_en = cs_s && (rd_active || status_mode);
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
// Property checker for the serial EEPROM slave, bound into its top.
// Assumes: reset is synchronous and active low.
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic sdo,
    input logic sdo_en,
    input logic busy,
    input logic commit,
    input logic prog_start,
    input logic wel,
    input logic rd_active,
    input logic dec_idle
);
    // R3: programming only ever starts with the latch set.
    p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wel);

    // R4: a started step makes the timer busy on the next cycle.
    p_start_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    // R4: the commit cycle is the last busy cycle.
    p_commit_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

    // R5: an enabled status output reads 0 while busy.
    p_busy_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && busy) |-> !sdo);

    // R5: an enabled non-read output reads 1 once idle.
    p_ready_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && !rd_active && !busy) |-> sdo);

    // R6: the decoder stays idle for the whole programming step.
    p_busy_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dec_idle);

    // R7: the first read cycle presents the dummy zero.
    p_dummy_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_active) |-> !sdo);

endmodule

bind mw_eeprom_slave mw_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_en(sdo_en), .busy(busy),
    .commit(commit), .prog_start(prog_start), .wel(wel),
    .rd_active(rd_active), .dec_idle(dec_idle)
);

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
    localparam int PROG = 200;
    localparam int AW   = 10;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic sdo, sdo_en;
    int   n_checks = 0, n_fail = 0;
    logic done = 1'b0;
    logic [15:0] w;
    logic o;

    always #2 clk = ~clk;

    mw_eeprom_slave #(.PROG_CYCLES(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    // Stimulus table: {address, data}; written then read back in one loop.
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {10'd0,    16'hA5C3}, {10'd1,    16'h0001}, {10'd1023, 16'h8000},
        {10'd512,  16'hFFFE}, {10'd341,  16'h5AA5}, {10'd77,   16'h0000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One serial bit: drive data, sample the output, pulse the serial clock.
    task automatic sk_bit(input logic b, output logic ob);
        @(negedge clk) di = b;
        repeat (4) @(negedge clk);
        ob = sdo;
        sk = 1'b1;
        repeat (4) @(negedge clk);
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        logic d;
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i], d);
    endtask

    task automatic cs_up();
        @(negedge clk) cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk) cs = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic get_word(output logic [15:0] r);
        logic d;
        for (int i = 15; i >= 0; i--) begin
            sk_bit(1'b0, d);
            r[i] = d;
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [15:0] d);
        cs_up();
        send({29'd0, 3'b101}, 3);
        send({22'd0, a}, AW);
        send({16'd0, d}, 16);
        cs_down();
        repeat (PROG + 20) @(negedge clk);
    endtask

    task automatic do_ctrl(input logic [1:0] sub);
        cs_up();
        send({29'd0, 3'b100}, 3);
        send({30'd0, sub}, 2);
        send(32'd0, AW - 2);
        cs_down();
    endtask

    // Read one word; also checks the dummy bit and the output enable.
    task automatic do_read(input logic [9:0] a, input string req, output logic [15:0] r);
        logic d;
        cs_up();
        send({29'd0, 3'b110}, 3);
        send({22'd0, a}, AW);
        sk_bit(1'b0, d);
        check({req, " dummy"}, {15'd0, d}, 16'd0);
        get_word(r);
        check({req, " oe"}, {15'd0, sdo_en}, 16'd1);
        cs_down();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: output off after reset even with select high; words erased.
        cs_up();
        check("R10 oe after reset", {15'd0, sdo_en}, 16'd0);
        cs_down();
        do_read(10'd3, "R10", w);
        check("R10 erased word", w, 16'hFFFF);

        // R3: latch clear after reset, write has no effect.
        do_write(10'd5, 16'h1234);
        do_read(10'd5, "R3", w);
        check("R3 write while locked", w, 16'hFFFF);

        // R2: unlock code 11, then table of writes and read-backs (R4, R7).
        do_ctrl(2'b11);
        for (int i = 0; i < NV; i++) do_write(VEC[i][25:16], VEC[i][15:0]);
        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i][25:16], "R7", w);
            check("R4 R2 table read-back", w, VEC[i][15:0]);
        end

        // R8: stream from the top address wraps to 0 then 1.
        cs_up();
        send({29'd0, 3'b110}, 3);
        send(32'd1023, AW);
        sk_bit(1'b0, o);
        check("R8 dummy", {15'd0, o}, 16'd0);
        get_word(w); check("R8 word 1023", w, 16'h8000);
        get_word(w); check("R8 wrap word 0", w, 16'hA5C3);
        get_word(w); check("R8 word 1", w, 16'h0001);
        cs_down();

        // R1: leading zeros before the framing bit are ignored.
        cs_up();
        send({29'd0, 3'b000}, 3);
        send({29'd0, 3'b110}, 3);
        send(32'd341, AW);
        sk_bit(1'b0, o);
        get_word(w);
        check("R1 read after leading zeros", w, 16'h5AA5);
        cs_down();

        // R5/R6: status during busy; a lock instruction sent while busy is ignored.
        cs_up();
        send({29'd0, 3'b101}, 3);
        send(32'd16, AW);
        send(32'h0000_1234, 16);
        cs_down();
        cs_up();
        check("R5 busy oe", {15'd0, sdo_en}, 16'd1);
        check("R5 busy low", {15'd0, sdo}, 16'd0);
        send({29'd0, 3'b100}, 3);
        send(32'd0, AW);
        cs_down();
        repeat (PROG + 20) @(negedge clk);
        cs_up();
        check("R5 ready high", {15'd0, sdo}, 16'd1);
        check("R5 ready oe", {15'd0, sdo_en}, 16'd1);
        cs_down();
        check("R5 oe off with select low", {15'd0, sdo_en}, 16'd0);
        cs_up();
        check("R5 status persists", {15'd0, sdo}, 16'd1);
        send({31'd0, 1'b1}, 1);
        repeat (4) @(negedge clk);
        check("R5 status ends at framing bit", {15'd0, sdo_en}, 16'd0);
        cs_down();
        do_read(10'd16, "R4", w);
        check("R4 committed after delay", w, 16'h1234);
        do_write(10'd17, 16'h5678);
        do_read(10'd17, "R6", w);
        check("R6 lock during busy ignored", w, 16'h5678);

        // R3: lock code 00 blocks later writes.
        do_ctrl(2'b00);
        do_write(10'd18, 16'h4321);
        do_read(10'd18, "R3", w);
        check("R3 write after lock", w, 16'hFFFF);

        // R11: write-all code is a no-op and starts no status.
        do_ctrl(2'b11);
        cs_up();
        send({29'd0, 3'b100}, 3);
        send({30'd0, 2'b01}, 2);
        send(32'd0, AW - 2);
        send(32'd0, 16);
        cs_down();
        cs_up();
        check("R11 no status", {15'd0, sdo_en}, 16'd0);
        cs_down();
        repeat (PROG + 20) @(negedge clk);
        do_read(10'd19, "R11", w);
        check("R11 word untouched", w, 16'hFFFF);

        // R9: abort mid-address and mid-data.
        cs_up();
        send({29'd0, 3'b101}, 3);
        send(32'd5, 5);
        cs_down();
        cs_up();
        send({29'd0, 3'b101}, 3);
        send(32'd32, AW);
        send(32'h0000_00AB, 8);
        cs_down();
        repeat (PROG + 20) @(negedge clk);
        do_read(10'd32, "R9", w);
        check("R9 aborted write", w, 16'hFFFF);

        // R3: reset clears the latch.
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        do_write(10'd33, 16'hBEEF);
        do_read(10'd33, "R3", w);
        check("R3 latch cleared by reset", w, 16'hFFFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule